// File: doc/BRIEF.md
# Variable-Frequency Integral Current Regulator

This block regulates the average current in an inductive load by switching a single driver. It has no fixed ramp. The switching period is free to move, and two coupled integrators decide the switch points. The current integrator sums the difference between the setpoint and the measured current, scaled by a power of two. The frequency integrator adjusts the switch-off level that the current integral has to fall through. It is updated once per switching period by the difference between the measured period and the target period, also scaled by a power of two. The driver turns off when the current integral falls through the frequency-integral level. It turns on when the current integral rises through zero.

A control step happens on each clock where `step_en` is high, and all state moves only on those steps. Two events start a transient state. The first is a setpoint change while auto-limit is enabled. The second is a switching period that has run longer than a chosen multiple of the target period. In the transient state the current integral is held between two limits set as powers of two, and the frequency integral is forced to a preset derived from the negative limit. A read-only monitor output brings out either integral or either limit.

Top module: `vfc_top`

## Requirements
- R1: After synchronous reset, `drive_on`, `in_transient` and `period_meas` are 0, and both integrals are 0.
- R2: On each step, the current integral gains (setpoint − meas_cur) × 2^ki_sel.
- R3: Both integrals saturate at the signed ACC_W word limits and never wrap: +2^(ACC_W−1)−1 and −2^(ACC_W−1).
- R4: While the driver is on, a step turns it off when the integral was at or above the frequency integral before the step and is below it after the step.
- R5: While the driver is off, a step turns it on when the integral was below 0 before the step and is at or above 0 after the step.
- R6: The period is the number of steps between consecutive switch-on steps, saturating at 2^CNT_W−1. It is loaded into `period_meas` on a switch-on step. On that same step, outside transient, the frequency integral gains (period − target_per) × 2^kfi_sel.
- R7: With `auto_lim` = 1, a step whose setpoint differs from the setpoint of the previous step enters transient. With `auto_lim` = 0, such a step does not enter transient.
- R8: A step enters transient when the step count since the last switch-on exceeds floor(M × target_per), where long_sel 0/1/2/3 selects M = 2.5/4.5/8.5/16.5.
- R9: On a step in transient, and on the step that triggers it, the current integral is clamped to [−2^neg_sel − 1, 2^pos_sel − 1].
- R10: On those same steps the frequency integral is loaded with a preset. The preset is 0 when fstart_sel = 0. Otherwise it is the negative limit arithmetically shifted right by 7 − fstart_sel.
- R11: Transient ends at the first switch-off step on which no trigger is active.
- R12: `mon_val` gives the frequency integral for mon_sel 00, the current integral for 01, the negative limit for 10 and the positive limit for 11.
- R13: On cycles with `step_en` low, no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Control step strobe |
| setpoint | input | CUR_W | Current setpoint code |
| meas_cur | input | CUR_W | Measured current code |
| target_per | input | PER_W | Target period in steps |
| ki_sel | input | 3 | Current integrator gain exponent |
| kfi_sel | input | 3 | Frequency integrator gain exponent |
| auto_lim | input | 1 | Setpoint change starts transient |
| long_sel | input | 2 | Long-period multiplier select |
| pos_sel | input | 4 | Positive clamp exponent |
| neg_sel | input | 4 | Negative clamp exponent |
| fstart_sel | input | 3 | Frequency preset select |
| mon_sel | input | 2 | Monitor select |
| drive_on | output | 1 | Driver command |
| in_transient | output | 1 | Transient state flag |
| period_meas | output | CNT_W | Last measured period in steps |
| mon_val | output | ACC_W | Monitor value, signed |

## Verification
A wrong current-integral value shows on `mon_val` with select 01 in the cycle after the step that caused it. It also moves the next switch edge on `drive_on`. A corrupted frequency integral changes the switch-off step and shows on select 00 right after the switch-on step that updated it. Transient errors show on `in_transient` one clock after the triggering step, and as clamped or preset values on the monitor. A wrong period count appears on `period_meas` at the next switch-on. Through R8 it can also start a transient too early or too late.

// File: rtl/vfc_pkg.sv
package vfc_pkg;

    localparam int CUR_W_D = 13;
    localparam int PER_W_D = 11;
    localparam int ACC_W_D = 20;

    typedef enum logic [1:0] {
        MON_FINT = 2'b00,
        MON_CINT = 2'b01,
        MON_NEG  = 2'b10,
        MON_POS  = 2'b11
    } mon_sel_e;

    typedef struct packed {
        logic [2:0] ki_sel;
        logic [2:0] kfi_sel;
        logic [3:0] pos_sel;
        logic [3:0] neg_sel;
        logic [2:0] fstart_sel;
        logic [1:0] long_sel;
        logic       auto_lim;
    } vfc_cfg_t;

    // twice the long-period multiplier: 2.5, 4.5, 8.5, 16.5
    function automatic logic [5:0] long_mult2(input logic [1:0] code);
        case (code)
            2'd0:    return 6'd5;
            2'd1:    return 6'd9;
            2'd2:    return 6'd17;
            default: return 6'd33;
        endcase
    endfunction

endpackage

// File: rtl/vfc_limits.sv
module vfc_limits #(
    parameter int ACC_W = 20
) (
    input  logic [3:0]              neg_sel,
    input  logic [3:0]              pos_sel,
    input  logic [2:0]              fstart_sel,
    output logic signed [ACC_W-1:0] neg_lim,
    output logic signed [ACC_W-1:0] pos_lim,
    output logic signed [ACC_W-1:0] preset
);
    logic signed [ACC_W-1:0] one;

    always_comb begin
        one     = ACC_W'(1);
        neg_lim = -(one <<< neg_sel) - one;
        pos_lim = (one <<< pos_sel) - one;
        if (fstart_sel == 3'd0)
            preset = '0;
        else
            preset = neg_lim >>> (3'd7 - fstart_sel);
    end
endmodule

// File: rtl/vfc_cur_int.sv
module vfc_cur_int #(
    parameter int CUR_W = 13,
    parameter int ACC_W = 20
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    step_en,
    input  logic [CUR_W-1:0]        setpoint,
    input  logic [CUR_W-1:0]        meas_cur,
    input  logic [2:0]              ki_sel,
    input  logic                    clamp_en,
    input  logic signed [ACC_W-1:0] neg_lim,
    input  logic signed [ACC_W-1:0] pos_lim,
    output logic signed [ACC_W-1:0] cur_q,
    output logic signed [ACC_W-1:0] cur_nxt
);
    localparam int WIDE = ACC_W + CUR_W + 9;
    localparam logic signed [ACC_W-1:0] MAX_A = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MIN_A = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic signed [WIDE-1:0]  HI_W  = WIDE'(MAX_A);
    localparam logic signed [WIDE-1:0]  LO_W  = WIDE'(MIN_A);

    logic signed [CUR_W:0]   err;
    logic signed [WIDE-1:0]  err_w;
    logic signed [WIDE-1:0]  sum;
    logic signed [ACC_W-1:0] sat;

    always_comb begin
        err   = $signed({1'b0, setpoint}) - $signed({1'b0, meas_cur});
        err_w = WIDE'(err);
        sum   = WIDE'(cur_q) + (err_w <<< ki_sel);
        if (sum > HI_W)
            sat = MAX_A;
        else if (sum < LO_W)
            sat = MIN_A;
        else
            sat = sum[ACC_W-1:0];
        if (clamp_en && sat > pos_lim)
            cur_nxt = pos_lim;
        else if (clamp_en && sat < neg_lim)
            cur_nxt = neg_lim;
        else
            cur_nxt = sat;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= '0;
        else if (step_en)
            cur_q <= cur_nxt;
    end
endmodule

// File: rtl/vfc_freq.sv
module vfc_freq #(
    parameter int PER_W = 11,
    parameter int ACC_W = 20,
    localparam int CNT_W = PER_W + 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    step_en,
    input  logic                    on_evt,
    input  logic                    preset_en,
    input  logic signed [ACC_W-1:0] preset,
    input  logic [PER_W-1:0]        target_per,
    input  logic [2:0]              kfi_sel,
    output logic signed [ACC_W-1:0] f_q,
    output logic [CNT_W-1:0]        run_cnt,
    output logic [CNT_W-1:0]        period_q
);
    localparam int WIDE = ACC_W + CNT_W + 9;
    localparam logic [CNT_W-1:0]        CMAX  = '1;
    localparam logic signed [ACC_W-1:0] MAX_A = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MIN_A = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic signed [WIDE-1:0]  HI_W  = WIDE'(MAX_A);
    localparam logic signed [WIDE-1:0]  LO_W  = WIDE'(MIN_A);

    logic [CNT_W-1:0]        new_per;
    logic signed [CNT_W+1:0] perr;
    logic signed [WIDE-1:0]  perr_w;
    logic signed [WIDE-1:0]  fsum;
    logic signed [ACC_W-1:0] fsat;

    always_comb begin
        new_per = (run_cnt == CMAX) ? run_cnt : run_cnt + 1'b1;
        perr    = $signed({2'b00, new_per})
                - $signed({{(CNT_W+2-PER_W){1'b0}}, target_per});
        perr_w  = WIDE'(perr);
        fsum    = WIDE'(f_q) + (perr_w <<< kfi_sel);
        if (fsum > HI_W)
            fsat = MAX_A;
        else if (fsum < LO_W)
            fsat = MIN_A;
        else
            fsat = fsum[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q      <= '0;
            run_cnt  <= '0;
            period_q <= '0;
        end else if (step_en) begin
            if (on_evt) begin
                run_cnt  <= '0;
                period_q <= new_per;
            end else begin
                run_cnt  <= new_per;
            end
            if (preset_en)
                f_q <= preset;
            else if (on_evt)
                f_q <= fsat;
        end
    end
endmodule

// File: rtl/vfc_trans.sv
module vfc_trans
    import vfc_pkg::*;
#(
    parameter int CUR_W = 13,
    parameter int PER_W = 11,
    localparam int CNT_W = PER_W + 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic [CUR_W-1:0] setpoint,
    input  logic             auto_lim,
    input  logic [1:0]       long_sel,
    input  logic [PER_W-1:0] target_per,
    input  logic [CNT_W-1:0] run_cnt,
    input  logic             off_evt,
    output logic             trans_q,
    output logic             trans_act
);
    logic [CUR_W-1:0] sp_q;
    logic [CNT_W-1:0] prod;
    logic [CNT_W-1:0] thr;
    logic             trig;

    always_comb begin
        prod      = CNT_W'(long_mult2(long_sel)) * CNT_W'(target_per);
        thr       = prod >> 1;
        trig      = step_en && ((auto_lim && (setpoint != sp_q)) || (run_cnt > thr));
        trans_act = trans_q || trig;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q    <= '0;
            trans_q <= 1'b0;
        end else if (step_en) begin
            sp_q <= setpoint;
            if (trig)
                trans_q <= 1'b1;
            else if (trans_q && off_evt)
                trans_q <= 1'b0;
        end
    end
endmodule

// File: rtl/vfc_top.sv
module vfc_top
    import vfc_pkg::*;
#(
    parameter int CUR_W = CUR_W_D,
    parameter int PER_W = PER_W_D,
    parameter int ACC_W = ACC_W_D,
    localparam int CNT_W = PER_W + 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    step_en,
    input  logic [CUR_W-1:0]        setpoint,
    input  logic [CUR_W-1:0]        meas_cur,
    input  logic [PER_W-1:0]        target_per,
    input  logic [2:0]              ki_sel,
    input  logic [2:0]              kfi_sel,
    input  logic                    auto_lim,
    input  logic [1:0]              long_sel,
    input  logic [3:0]              pos_sel,
    input  logic [3:0]              neg_sel,
    input  logic [2:0]              fstart_sel,
    input  logic [1:0]              mon_sel,
    output logic                    drive_on,
    output logic                    in_transient,
    output logic [CNT_W-1:0]        period_meas,
    output logic signed [ACC_W-1:0] mon_val
);
    vfc_cfg_t cfg;
    mon_sel_e msel;

    assign cfg = '{ki_sel: ki_sel, kfi_sel: kfi_sel, pos_sel: pos_sel,
                   neg_sel: neg_sel, fstart_sel: fstart_sel,
                   long_sel: long_sel, auto_lim: auto_lim};
    assign msel = mon_sel_e'(mon_sel);

    logic signed [ACC_W-1:0] neg_lim, pos_lim, preset;
    logic signed [ACC_W-1:0] cur_q, cur_nxt, f_q;
    logic [CNT_W-1:0]        run_cnt;
    logic                    trans_act, trans_q;
    logic                    drv_q, on_evt, off_evt;

    vfc_limits #(.ACC_W(ACC_W)) u_lim (
        .neg_sel(cfg.neg_sel), .pos_sel(cfg.pos_sel), .fstart_sel(cfg.fstart_sel),
        .neg_lim(neg_lim), .pos_lim(pos_lim), .preset(preset)
    );

    vfc_cur_int #(.CUR_W(CUR_W), .ACC_W(ACC_W)) u_cur (
        .clk(clk), .rst(rst), .step_en(step_en),
        .setpoint(setpoint), .meas_cur(meas_cur), .ki_sel(cfg.ki_sel),
        .clamp_en(trans_act), .neg_lim(neg_lim), .pos_lim(pos_lim),
        .cur_q(cur_q), .cur_nxt(cur_nxt)
    );

    // crossing detection against the value held before this step
    always_comb begin
        off_evt = step_en && drv_q && (cur_q >= f_q) && (cur_nxt < f_q);
        on_evt  = step_en && !drv_q && (cur_q < 0) && (cur_nxt >= 0);
    end

    vfc_freq #(.PER_W(PER_W), .ACC_W(ACC_W)) u_freq (
        .clk(clk), .rst(rst), .step_en(step_en), .on_evt(on_evt),
        .preset_en(trans_act), .preset(preset), .target_per(target_per),
        .kfi_sel(cfg.kfi_sel), .f_q(f_q), .run_cnt(run_cnt), .period_q(period_meas)
    );

    vfc_trans #(.CUR_W(CUR_W), .PER_W(PER_W)) u_trans (
        .clk(clk), .rst(rst), .step_en(step_en), .setpoint(setpoint),
        .auto_lim(cfg.auto_lim), .long_sel(cfg.long_sel), .target_per(target_per),
        .run_cnt(run_cnt), .off_evt(off_evt), .trans_q(trans_q), .trans_act(trans_act)
    );

    always_ff @(posedge clk) begin
        if (rst)
            drv_q <= 1'b0;
        else if (off_evt)
            drv_q <= 1'b0;
        else if (on_evt)
            drv_q <= 1'b1;
    end

    always_comb begin
        case (msel)
            MON_FINT: mon_val = f_q;
            MON_CINT: mon_val = cur_q;
            MON_NEG:  mon_val = neg_lim;
            default:  mon_val = pos_lim;
        endcase
    end

    assign drive_on     = drv_q;
    assign in_transient = trans_q;
endmodule

// File: rtl/vfc_chk.sv
module vfc_chk #(
    parameter int ACC_W = 20,
    parameter int CNT_W = 17
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    step_en,
    input logic                    drive_on,
    input logic                    in_transient,
    input logic [CNT_W-1:0]        period_meas,
    input logic signed [ACC_W-1:0] cur_q,
    input logic signed [ACC_W-1:0] f_q,
    input logic signed [ACC_W-1:0] neg_lim,
    input logic signed [ACC_W-1:0] pos_lim
);
    // R13
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(step_en) |-> ($stable(drive_on) && $stable(in_transient) && $stable(period_meas)));

    // R5
    switch_on_cross_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_on) |-> ($past(cur_q) < 0 && cur_q >= 0));

    // R4
    switch_off_cross_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(drive_on) |-> ($past(cur_q) >= $past(f_q) && cur_q < $past(f_q)));

    // R9
    transient_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(step_en) && in_transient) |-> (cur_q <= $past(pos_lim) && cur_q >= $past(neg_lim)));

    // R6
    period_loaded_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_on) |-> (period_meas != '0));
endmodule

bind vfc_top vfc_chk #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .step_en(step_en), .drive_on(drive_on),
    .in_transient(in_transient), .period_meas(period_meas),
    .cur_q(cur_q), .f_q(f_q), .neg_lim(neg_lim), .pos_lim(pos_lim)
);

// File: tb/tb_vfc_top.sv
`timescale 1ns/1ps
module tb_vfc_top;
    localparam int CUR_W = 13;
    localparam int PER_W = 11;
    localparam int ACC_W = 20;
    localparam int CNT_W = PER_W + 6;
    localparam longint AMAX = (64'sd1 <<< (ACC_W-1)) - 1;
    localparam longint AMIN = -(64'sd1 <<< (ACC_W-1));
    localparam longint CMAX = (64'sd1 <<< CNT_W) - 1;

    logic clk = 0, rst = 1, step_en = 0, auto_lim = 0;
    logic [CUR_W-1:0] setpoint = 0, meas_cur = 0;
    logic [PER_W-1:0] target_per = 0;
    logic [2:0] ki_sel = 0, kfi_sel = 0, fstart_sel = 0;
    logic [1:0] long_sel = 0, mon_sel = 0;
    logic [3:0] pos_sel = 0, neg_sel = 0;
    logic drive_on, in_transient;
    logic [CNT_W-1:0] period_meas;
    logic signed [ACC_W-1:0] mon_val;

    int n_chk = 0, n_bad = 0;
    longint m_cur, m_f, m_cnt, m_per, m_sp;
    bit m_drv, m_tr;

    always #2.5 clk = ~clk;

    vfc_top dut (.*);

    function automatic longint sat(longint v);
        if (v > AMAX) return AMAX;
        if (v < AMIN) return AMIN;
        return v;
    endfunction
    function automatic longint negl();
        return -(64'sd1 <<< neg_sel) - 1;
    endfunction
    function automatic longint posl();
        return (64'sd1 <<< pos_sel) - 1;
    endfunction
    function automatic longint fpreset();
        if (fstart_sel == 0) return 0;
        return negl() >>> (7 - fstart_sel);
    endfunction
    function automatic longint long_thr();
        longint m2;
        case (long_sel)
            2'd0: m2 = 5;
            2'd1: m2 = 9;
            2'd2: m2 = 17;
            default: m2 = 33;
        endcase
        return (m2 * target_per) / 2;
    endfunction
    function automatic longint exp_mon();
        case (mon_sel)
            2'd0: return m_f;
            2'd1: return m_cur;
            2'd2: return negl();
            default: return posl();
        endcase
    endfunction

    task automatic chk(string tag, longint got, longint exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        m_cur = 0; m_f = 0; m_cnt = 0; m_per = 0; m_sp = 0; m_drv = 0; m_tr = 0;
    endtask

    task automatic model_next();
        longint sum, nxt, np;
        bit trig, act, on_e, off_e;
        if (!step_en) return;
        trig = (auto_lim && longint'(setpoint) != m_sp) || (m_cnt > long_thr());
        act  = m_tr || trig;
        sum  = sat(m_cur + (longint'(setpoint) - longint'(meas_cur)) * (64'sd1 <<< ki_sel));
        nxt  = sum;
        if (act && nxt > posl()) nxt = posl();
        if (act && nxt < negl()) nxt = negl();
        off_e = m_drv && m_cur >= m_f && nxt < m_f;
        on_e  = !m_drv && m_cur < 0 && nxt >= 0;
        np = (m_cnt == CMAX) ? CMAX : m_cnt + 1;
        if (act) m_f = fpreset();
        else if (on_e) m_f = sat(m_f + (np - target_per) * (64'sd1 <<< kfi_sel));
        if (on_e) begin m_per = np; m_cnt = 0; end
        else m_cnt = np;
        if (off_e) m_drv = 0;
        if (on_e) m_drv = 1;
        if (trig) m_tr = 1;
        else if (m_tr && off_e) m_tr = 0;
        m_cur = nxt;
        m_sp = setpoint;
    endtask

    // tag names the requirement behind each compared port
    task automatic compare(string tag);
        chk({tag, "/R4 drive"}, drive_on, m_drv);
        chk({tag, "/R11 transient"}, in_transient, m_tr);
        chk({tag, "/R6 period"}, period_meas, m_per);
        chk({tag, "/R12 monitor"}, mon_val, exp_mon());
    endtask

    task automatic cyc(string tag);
        model_next();
        @(posedge clk); #1;
        compare(tag);
        @(negedge clk);
    endtask

    task automatic peek(logic [1:0] sel, string tag, longint exp);
        mon_sel = sel; #0.5;
        chk(tag, mon_val, exp);
    endtask

    task automatic do_reset();
        rst = 1; step_en = 0;
        repeat (3) @(negedge clk);
        rst = 0; model_reset();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int k;
        int rnd;
        rnd = $urandom(32'h5a17);
        @(negedge clk);
        do_reset();
        #1;
        // R1 reset state
        chk("R1 drive", drive_on, 0);
        chk("R1 transient", in_transient, 0);
        chk("R1 period", period_meas, 0);
        peek(2'b01, "R1 cur integral", 0);
        peek(2'b00, "R1 freq integral", 0);

        // R2 one step of the current integrator
        target_per = 2000; long_sel = 3; auto_lim = 0;
        setpoint = 100; meas_cur = 40; ki_sel = 3; kfi_sel = 0;
        step_en = 1; mon_sel = 2'b01;
        cyc("R2");
        peek(2'b01, "R2 integral", 480);

        // R13 no step: nothing moves
        step_en = 0; setpoint = 5000;
        repeat (3) cyc("R13");
        peek(2'b01, "R13 integral held", 480);
        chk("R13 drive held", drive_on, 0);

        // R3 saturation both ways
        step_en = 1; setpoint = 8191; meas_cur = 0; ki_sel = 7;
        cyc("R3");
        peek(2'b01, "R3 top limit", AMAX);
        setpoint = 0; meas_cur = 8191;
        cyc("R3"); cyc("R3");
        peek(2'b01, "R3 bottom limit", AMIN);

        // R5 rising through zero turns the driver on
        setpoint = 8191; meas_cur = 0;
        cyc("R5");
        chk("R5 drive on", drive_on, 1);

        // R7 auto-limit off: setpoint change ignored
        setpoint = 3000; meas_cur = 3000;
        cyc("R7");
        chk("R7 no transient with auto_lim=0", in_transient, 0);

        // R7/R9/R10 auto-limit on: setpoint change enters transient
        pos_sel = 4; neg_sel = 3; fstart_sel = 5; auto_lim = 1;
        setpoint = 6000; meas_cur = 0;
        cyc("R7");
        chk("R7 transient entered", in_transient, 1);
        peek(2'b01, "R9 clamped to positive limit", 15);
        peek(2'b00, "R10 preset sel5", -3);
        peek(2'b10, "R12 negative limit", -9);
        peek(2'b11, "R12 positive limit", 15);

        // R4/R11 falling through the frequency level ends transient
        meas_cur = 8191;
        cyc("R11");
        chk("R4 drive off", drive_on, 0);
        chk("R11 transient left", in_transient, 0);
        peek(2'b01, "R9 clamped to negative limit", -9);

        // R8 long period: threshold floor(2.5*4)=10
        auto_lim = 0; meas_cur = 6000; target_per = 4; long_sel = 0;
        k = 0;
        while (!in_transient && k < 30) begin
            k++;
            cyc("R8");
        end
        chk("R8 steps to long-period entry", k, 9);
        fstart_sel = 0;
        cyc("R10");
        peek(2'b00, "R10 preset sel0", 0);
        fstart_sel = 7;
        cyc("R10");
        peek(2'b00, "R10 preset sel7", -9);

        // closed-loop random phase
        do_reset();
        meas_cur = 0; setpoint = 2000; ki_sel = 1; kfi_sel = 1;
        target_per = 20; long_sel = 1; pos_sel = 12; neg_sel = 12;
        fstart_sel = 6; auto_lim = 1;
        for (int i = 0; i < 6000; i++) begin
            step_en = ($urandom % 100) < 85;
            mon_sel = 2'($urandom);
            if ($urandom % 400 == 0) begin
                setpoint   = CUR_W'(500 + $urandom % 5000);
                ki_sel     = 3'($urandom % 4);
                kfi_sel    = 3'($urandom % 4);
                target_per = PER_W'(6 + $urandom % 40);
                long_sel   = 2'($urandom);
                auto_lim   = 1'($urandom);
                pos_sel    = 4'(8 + $urandom % 8);
                neg_sel    = 4'(8 + $urandom % 8);
                fstart_sel = 3'($urandom);
            end
            cyc("R6 random");
            if (step_en) begin
                if (drive_on) meas_cur = (meas_cur > 8191 - 70) ? 13'd8191 : meas_cur + 13'd70;
                else          meas_cur = (meas_cur < 50) ? 13'd0 : meas_cur - 13'd50;
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule